// File: doc/BRIEF.md
# 64-bit Target Acknowledge and Capability Logic

This block sits beside the target state machine of a bus bridge and decides, transaction by transaction, whether the bridge accepts a request for 64-bit data transfers. When the address decoder claims a transaction, the block raises its DEVSEL copy one clock later. In that same clock it raises ACK64, but only when four conditions hold. The primary 64-bit extension must have been detected at reset. The initiator must have requested 64-bit transfers. The command must be a memory write or a prefetchable memory read. For a read, at least two DWORDs must sit in the read buffer.

During a 64-bit read, the block counts down the buffered DWORDs by two per data phase. If the buffer ends on an odd DWORD, it requests a target disconnect before the last DWORD would have to be sent. It also produces the upper-half parity one clock after each 64-bit data phase.

While primary reset is active, the block samples the shared REQ64 pin and keeps the result as the 64-bit capability flag. During secondary reset it pulls the secondary REQ64 drive low to announce 64-bit support downstream.

Top module: `wide_target_ack64`

## Requirements
- R1: While `prim_rst_n` is low, `cap64` is updated every clock to the inverse of `req64_n`. After reset releases, it keeps the value sampled at the last reset clock.
- R2: Once `prim_rst_n` is high, `cap64` does not change, whatever `req64_n` does, until reset is asserted again.
- R3: `sec_req64_n` is low whenever `sec_rst_n` is low and high whenever `sec_rst_n` is high.
- R4: `devsel` goes high in the clock after a `claim` pulse. It stays high until the clock after `xfer_end`.
- R5: `ack64` is only ever high while `devsel` is high. It is high only when `req64_n` was low in the `claim` cycle and `cap64` is 1.
- R6: The command codes on `cmd` are 0 memory write, 1 prefetchable memory read, 2 non-prefetchable memory read, 3 I/O and 4 configuration. Given R5, `ack64` is granted for code 0 at any count, and for code 1 only when `rd_cnt` is at least 2. It is never granted for codes 2, 3 or 4.
- R7: In a read with `ack64` high, each `data_xfer` consumes two DWORDs of the count loaded at `claim`. `stop` is high exactly when one DWORD remains. An odd count therefore gives `stop` after (count-1)/2 data phases, and an even count never gives `stop`.
- R8: In the clock after a `data_xfer` made while `ack64` was high, `par64` equals the XOR of `ad_hi` and `cbe_hi_n` from that data phase (even parity). In every other clock, `par64` is 0.
- R9: While `prim_rst_n` is low, `devsel`, `ack64`, `stop` and `par64` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| prim_rst_n | input | 1 | Primary reset, active low, synchronous |
| sec_rst_n | input | 1 | Secondary reset, active low |
| req64_n | input | 1 | Primary REQ64, active low; capability strap during reset |
| cmd | input | 3 | Decoded command class (codes in R6) |
| rd_cnt | input | CNT_W | DWORDs held in the read buffer |
| claim | input | 1 | Address decode hit; DEVSEL follows next clock |
| data_xfer | input | 1 | A data phase completes this clock |
| xfer_end | input | 1 | Last clock of the transaction |
| ad_hi | input | 32 | Upper data half for the current data phase |
| cbe_hi_n | input | 4 | Upper byte enables for the current data phase |
| devsel | output | 1 | Target DEVSEL indication |
| ack64 | output | 1 | 64-bit acknowledge |
| stop | output | 1 | Disconnect request before an odd trailing DWORD |
| par64 | output | 1 | Upper-half parity |
| cap64 | output | 1 | Primary 64-bit extension present |
| sec_req64_n | output | 1 | Secondary REQ64 drive |

## Verification
The hardest case to reach is the odd-DWORD disconnect. It needs a capability flag learned in an earlier reset, a 64-bit request and a prefetchable read command all in the claim cycle, and then a run of data phases that drains the count to exactly one DWORD. The bench re-runs reset with each strap value. For each one, it sweeps every command code and buffer count from 0 to 9, with and without REQ64. For each granted read, it steps through data phases one at a time and checks `stop` and `par64` after every phase against a count and a parity that it computes itself.

// File: rtl/wt_pkg.sv
package wt_pkg;
    typedef enum logic [2:0] {
        CMD_MEM_WR = 3'd0,
        CMD_RD_PF  = 3'd1,
        CMD_RD_NP  = 3'd2,
        CMD_IO     = 3'd3,
        CMD_CFG    = 3'd4
    } wt_cmd_e;

    function automatic logic is_read(input wt_cmd_e c);
        return (c == CMD_RD_PF) || (c == CMD_RD_NP);
    endfunction
endpackage

// File: rtl/wt_cap_sample.sv
module wt_cap_sample (
    input  logic clk,
    input  logic prim_rst_n,
    input  logic req64_n,
    output logic cap64
);
    typedef struct packed {
        logic cap;
    } cap_state_t;

    cap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!prim_rst_n) begin
            st_d.cap = !req64_n;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cap64 = st_q.cap;

    AST_CAP_HOLDS: assert property (@(posedge clk) disable iff (!prim_rst_n)
        prim_rst_n |=> $stable(cap64)); // R2
endmodule

// File: rtl/wt_ack_ctrl.sv
module wt_ack_ctrl
    import wt_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap64,
    input  logic             req64_n,
    input  logic [2:0]       cmd,
    input  logic [CNT_W-1:0] rd_cnt,
    input  logic             claim,
    input  logic             data_xfer,
    input  logic             xfer_end,
    output logic             devsel,
    output logic             ack64,
    output logic             stop
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    typedef struct packed {
        logic             active;
        logic             wide;
        logic             rd;
        logic [CNT_W-1:0] rem;
        logic             stop;
    } ack_state_t;

    ack_state_t st_d, st_q;
    wt_cmd_e    cmd_e;
    logic       eligible;

    assign cmd_e = wt_cmd_e'(cmd);

    always_comb begin
        eligible = cap64 && !req64_n &&
                   ((cmd_e == CMD_MEM_WR) || ((cmd_e == CMD_RD_PF) && (rd_cnt >= TWO)));
    end

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d = '0;
        end else if (claim && !st_q.active) begin
            st_d.active = 1'b1;
            st_d.wide   = eligible;
            st_d.rd     = is_read(cmd_e);
            st_d.rem    = rd_cnt;
        end else if (st_q.active) begin
            if (xfer_end) begin
                st_d = '0;
            end else if (data_xfer) begin
                if (st_q.wide) begin
                    st_d.rem = (st_q.rem >= TWO) ? st_q.rem - TWO : '0;
                end else begin
                    st_d.rem = (st_q.rem >= ONE) ? st_q.rem - ONE : '0;
                end
            end
        end
        st_d.stop = st_d.active && st_d.wide && st_d.rd && (st_d.rem == ONE);
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign devsel = st_q.active;
    assign ack64  = st_q.active && st_q.wide;
    assign stop   = st_q.stop;

    AST_DEVSEL_FOLLOWS_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
        (claim && !devsel) |=> devsel); // R4
    AST_NARROW_CMD_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (claim && !devsel && (cmd >= 3'd2)) |=> !ack64); // R6
    AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack64) |-> ($past(claim) && !$past(req64_n) && $past(cap64))); // R5
    AST_STOP_AFTER_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop) |-> ($past(claim) || $past(data_xfer))); // R7
endmodule

// File: rtl/wt_par64.sv
module wt_par64 (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ack64,
    input  logic        data_xfer,
    input  logic [31:0] ad_hi,
    input  logic [3:0]  cbe_hi_n,
    output logic        par64
);
    typedef struct packed {
        logic par;
    } par_state_t;

    par_state_t st_d, st_q;

    always_comb begin
        st_d.par = 1'b0;
        if (rst_n && ack64 && data_xfer) begin
            st_d.par = ^{ad_hi, cbe_hi_n};
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign par64 = st_q.par;

    AST_PAR_ONLY_AFTER_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        par64 |-> ($past(ack64) && $past(data_xfer))); // R8
endmodule

// File: rtl/wide_target_ack64.sv
module wide_target_ack64 #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             prim_rst_n,
    input  logic             sec_rst_n,
    input  logic             req64_n,
    input  logic [2:0]       cmd,
    input  logic [CNT_W-1:0] rd_cnt,
    input  logic             claim,
    input  logic             data_xfer,
    input  logic             xfer_end,
    input  logic [31:0]      ad_hi,
    input  logic [3:0]       cbe_hi_n,
    output logic             devsel,
    output logic             ack64,
    output logic             stop,
    output logic             par64,
    output logic             cap64,
    output logic             sec_req64_n
);
    logic cap_w;
    logic ack_w;

    wt_cap_sample u_cap (
        .clk        (clk),
        .prim_rst_n (prim_rst_n),
        .req64_n    (req64_n),
        .cap64      (cap_w)
    );

    wt_ack_ctrl #(.CNT_W(CNT_W)) u_ack (
        .clk       (clk),
        .rst_n     (prim_rst_n),
        .cap64     (cap_w),
        .req64_n   (req64_n),
        .cmd       (cmd),
        .rd_cnt    (rd_cnt),
        .claim     (claim),
        .data_xfer (data_xfer),
        .xfer_end  (xfer_end),
        .devsel    (devsel),
        .ack64     (ack_w),
        .stop      (stop)
    );

    wt_par64 u_par (
        .clk       (clk),
        .rst_n     (prim_rst_n),
        .ack64     (ack_w),
        .data_xfer (data_xfer),
        .ad_hi     (ad_hi),
        .cbe_hi_n  (cbe_hi_n),
        .par64     (par64)
    );

    assign cap64       = cap_w;
    assign ack64       = ack_w;
    assign sec_req64_n = sec_rst_n;

    AST_ACK_INSIDE_DEVSEL: assert property (@(posedge clk) disable iff (!prim_rst_n)
        ack64 |-> devsel); // R5
    AST_SEC_REQ_LOW: assert property (@(posedge clk) disable iff (!prim_rst_n)
        !sec_rst_n |-> !sec_req64_n); // R3
endmodule

// File: tb/sim_wide_target_ack64.sv
module sim_wide_target_ack64;
    localparam int CNT_W = 5;

    logic             clk = 1'b0;
    logic             prim_rst_n = 1'b0;
    logic             sec_rst_n = 1'b0;
    logic             req64_n = 1'b1;
    logic [2:0]       cmd = '0;
    logic [CNT_W-1:0] rd_cnt = '0;
    logic             claim = 1'b0;
    logic             data_xfer = 1'b0;
    logic             xfer_end = 1'b0;
    logic [31:0]      ad_hi = '0;
    logic [3:0]       cbe_hi_n = '0;
    logic devsel, ack64, stop, par64, cap64, sec_req64_n;

    int n_tests = 0;
    int n_fail  = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    wide_target_ack64 #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .prim_rst_n(prim_rst_n), .sec_rst_n(sec_rst_n), .req64_n(req64_n),
        .cmd(cmd), .rd_cnt(rd_cnt), .claim(claim), .data_xfer(data_xfer),
        .xfer_end(xfer_end), .ad_hi(ad_hi), .cbe_hi_n(cbe_hi_n), .devsel(devsel),
        .ack64(ack64), .stop(stop), .par64(par64), .cap64(cap64), .sec_req64_n(sec_req64_n)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        prim_rst_n = 1'b0;
        req64_n = strap;
        repeat (3) cyc();
        chk("R9 devsel", devsel, 1'b0);
        chk("R9 ack64", ack64, 1'b0);
        chk("R9 stop", stop, 1'b0);
        chk("R9 par64", par64, 1'b0);
        chk("R1 cap64 in reset", cap64, !strap);
        @(negedge clk);
        prim_rst_n = 1'b1;
        req64_n = 1'b1;
        cyc();
        chk("R1 cap64 after release", cap64, !strap);
    endtask

    task automatic run_txn(input logic cap, input logic rq, input int c, input int cnt);
        logic exp_w;
        logic rd;
        int rem;
        logic [35:0] pat;
        exp_w = cap && !rq && ((c == 0) || (c == 1 && cnt >= 2));
        rd = (c == 1) || (c == 2);
        @(negedge clk);
        claim = 1'b1; req64_n = rq; cmd = 3'(c); rd_cnt = CNT_W'(cnt);
        cyc();
        chk("R4 devsel after claim", devsel, 1'b1);
        chk("R6 ack64 decision", ack64, exp_w);
        chk("R7 stop at start", stop, exp_w && rd && (cnt == 1));
        @(negedge clk);
        claim = 1'b0; req64_n = 1'b1;
        rem = cnt;
        for (int k = 0; k < 6; k++) begin
            if (exp_w && rd && rem == 1) break;
            if (rem == 0) break;
            @(negedge clk);
            pat = {4'(k + c), 32'hA5C3_0000 ^ 32'(cnt * 977 + k * 31)};
            data_xfer = 1'b1; ad_hi = pat[31:0]; cbe_hi_n = pat[35:32];
            cyc();
            chk("R8 par64", par64, exp_w ? ^pat : 1'b0);
            rem = exp_w ? ((rem >= 2) ? rem - 2 : 0) : rem - 1;
            chk("R7 stop after phase", stop, exp_w && rd && (rem == 1));
            chk("R5 ack64 held", ack64, exp_w);
            @(negedge clk);
            data_xfer = 1'b0;
            cyc();
            chk("R8 par64 idle", par64, 1'b0);
        end
        @(negedge clk);
        xfer_end = 1'b1;
        cyc();
        chk("R4 devsel released", devsel, 1'b0);
        chk("R5 ack64 released", ack64, 1'b0);
        @(negedge clk);
        xfer_end = 1'b0;
    endtask

    initial begin
        #2;
        chk("R3 sec drive in reset", sec_req64_n, 1'b0);
        @(negedge clk);
        sec_rst_n = 1'b1;
        #1;
        chk("R3 sec drive released", sec_req64_n, 1'b1);
        for (int s = 0; s < 2; s++) begin
            logic cap;
            cap = (s == 1);
            do_reset(!cap);
            for (int r = 0; r < 2; r++) begin
                for (int c = 0; c < 5; c++) begin
                    for (int n = 0; n < 10; n++) begin
                        run_txn(cap, r[0], c, n);
                    end
                end
            end
            @(negedge clk);
            req64_n = cap;
            repeat (4) cyc();
            chk("R2 cap64 holds", cap64, cap);
            @(negedge clk);
            req64_n = 1'b1;
        end
        @(negedge clk);
        sec_rst_n = 1'b0;
        #1;
        chk("R3 sec drive reasserted", sec_req64_n, 1'b0);
        do_reset(1'b0);
        chk("R1 cap64 resampled", cap64, 1'b1);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule